// File: doc/BRIEF.md
# Dual-Bank Level/Edge Interrupt Controller

This block gathers 32 asynchronous interrupt lines and presents them to a processor through two register banks on a plain 32-bit register bus. The bus has an address, a write enable, write data, a read enable and read data. Each bank drives its own request output. The normal bank drives `irq_norm_o` and the fast bank drives `irq_fast_o`. Both banks share one layout. The fast bank sits 0x20 above the normal bank.

Every line passes through a two-flop synchroniser. In each bank, a pair of bits per line selects the trigger type:

| Trigger bit | Sense bit | Trigger type |
|---|---|---|
| 0 | 0 | Active-high level |
| 0 | 1 | Active-low level |
| 1 | 0 | Rising edge |
| 1 | 1 | Falling edge |

Level lines follow the synchronised input. Edge events are held in a per-line latch until software writes a one to the line's bit in the acknowledge register. A typical handler reads the status word, services the lowest set bit, acknowledges it, and reads status again until it is zero.

Top module: `irq_ctrl_dual`

## Requirements
- R1: After reset, every enable, trigger, sense and edge-latch bit is zero, both request outputs are low, and `bus_rdata` is zero.
- R2: Register offsets (byte addresses, word aligned) are as follows. The normal bank uses 0x00 raw-pending, 0x04 enable, 0x08 acknowledge, 0x0C trigger, 0x10 sense and 0x14 status. The fast bank uses the same offsets plus 0x20. Any other address reads zero, and a write to it changes nothing.
- R3: The enable, trigger and sense registers of each bank read back exactly the word last written to them.
- R4: A line with trigger 0 and sense 0 is pending while its input is high. Pending follows the input with no latching. The request output reflects an input change two clock edges after the input changes.
- R5: A line with trigger 0 and sense 1 is pending while its input is low.
- R6: A line with trigger 1 and sense 0 latches a pending bit on a rising input. The request output rises three clock edges after the input edge, and the bit stays set after the input falls.
- R7: A line with trigger 1 and sense 1 latches a pending bit on a falling input. A rising input does not set it.
- R8: A write of 1 to an acknowledge bit clears that line's edge latch, and a 0 bit leaves the latch unchanged. The acknowledge register reads zero.
- R9: The raw-pending register shows the pending state before the enable mask. The status register equals raw-pending AND enable (bit n = line n).
- R10: Each request output is the OR of its bank's status bits. With the enable register at zero, the output stays low whatever the inputs do.
- R11: The two banks are independent. One bank's configuration and latches do not affect the other bank's registers or output.
- R12: If an acknowledge write and a new edge event on the same line occur in the same cycle, the new event wins and the bit stays latched.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_re` is sampled high. It is zero in the cycle after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 32 | Asynchronous interrupt inputs |
| irq_norm_o | output | 1 | Normal-bank request |
| irq_fast_o | output | 1 | Fast-bank request |

## Verification
The results have fixed latencies:

| Result | Due after the stimulus |
|---|---|
| Register write | One edge after it is sampled |
| Read data | One edge after the read strobe |
| Level-mode pending bit | Two edges after an input change, through the synchroniser |
| Edge latch | Three edges after an input change |

The bench drives stimulus on falling clock edges and counts rising edges explicitly before sampling. It checks that the request output has not yet moved one edge early, and that it has moved on the due edge. The same-cycle acknowledge-and-edge case places the acknowledge write exactly on the third edge after the input change.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // Register index within a bank: address bits [4:2].
  typedef enum logic [2:0] {
    SEL_RAW  = 3'd0,
    SEL_EN   = 3'd1,
    SEL_ACK  = 3'd2,
    SEL_TRIG = 3'd3,
    SEL_SENS = 3'd4,
    SEL_STAT = 3'd5
  } reg_sel_e;

  localparam int unsigned N_BANKS  = 2;
  localparam int unsigned BANK_BIT = 5;   // byte offset 0x20 selects the fast bank
  localparam int unsigned SEL_LSB  = 2;
  localparam int unsigned SEL_W    = 3;

  function automatic logic sel_is_mapped(input logic [SEL_W-1:0] s);
    return s <= SEL_STAT;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] sync_o,
  output logic [N_LINES-1:0] prev_o
);
  logic [N_LINES-1:0] meta_q, sync_q, prev_q;
  logic [1:0]         age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      age_q  <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (sync_q == $past(raw_i, 2))); // R4
  AST_PREV_IS_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (prev_q == $past(sync_q))); // R6
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] sync_i,
  input  logic [N_LINES-1:0] prev_i,
  input  logic               we_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] rword_o,
  output logic               irq_o
);
  // Level pending: the sense bit inverts the synchronised input.
  function automatic logic [N_LINES-1:0] level_pend(
    input logic [N_LINES-1:0] s, input logic [N_LINES-1:0] sense);
    return s ^ sense;
  endfunction

  // Edge hit: the input changed, and its new value is the active one.
  function automatic logic [N_LINES-1:0] edge_hit(
    input logic [N_LINES-1:0] s, input logic [N_LINES-1:0] d,
    input logic [N_LINES-1:0] sense);
    return (s ^ d) & (s ^ sense);
  endfunction

  logic [N_LINES-1:0] en_q, trig_q, sens_q, latch_q;
  logic [N_LINES-1:0] ack_w, edge_evt, raw_pend, status;

  assign ack_w    = (we_i && sel_i == SEL_ACK) ? wdata_i : '0;
  assign edge_evt = trig_q & edge_hit(sync_i, prev_i, sens_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      trig_q <= '0;
      sens_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_EN)   en_q   <= wdata_i;
      if (sel_i == SEL_TRIG) trig_q <= wdata_i;
      if (sel_i == SEL_SENS) sens_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rst_n) latch_q[i] <= 1'b0;
      else        latch_q[i] <= edge_evt[i] | (latch_q[i] & ~ack_w[i]);
    end
  end

  assign raw_pend = (trig_q & latch_q) | (~trig_q & level_pend(sync_i, sens_q));
  assign status   = raw_pend & en_q;
  assign irq_o    = |status;

  always_comb begin
    unique case (sel_i)
      SEL_RAW:  rword_o = raw_pend;
      SEL_EN:   rword_o = en_q;
      SEL_TRIG: rword_o = trig_q;
      SEL_SENS: rword_o = sens_q;
      SEL_STAT: rword_o = status;
      default:  rword_o = '0;
    endcase
  end

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(latch_q & ~ack_w)) & ~latch_q) == '0)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(ack_w & ~edge_evt)) == '0)); // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~latch_q & $past(edge_evt)) == '0)); // R12
  AST_EN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_EN) |=> (en_q == $past(wdata_i))); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R10
endmodule

// File: rtl/irq_ctrl_dual.sv
module irq_ctrl_dual
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_LINES-1:0] irq_lines,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  localparam int unsigned HI_LSB = BANK_BIT + 1;

  logic [N_LINES-1:0] sync_w, prev_w;
  logic               addr_ok;
  logic               bank_w;
  logic [SEL_W-1:0]   sel_w;
  logic [N_LINES-1:0] rword [N_BANKS];
  logic [N_BANKS-1:0] irq_v;
  logic [DATA_W-1:0]  rd_next;

  assign addr_ok = (bus_addr[ADDR_W-1:HI_LSB] == '0) && (bus_addr[1:0] == 2'b00)
                   && sel_is_mapped(sel_w);
  assign bank_w  = bus_addr[BANK_BIT];
  assign sel_w   = bus_addr[SEL_LSB +: SEL_W];

  irq_sync #(.N_LINES(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_lines),
    .sync_o(sync_w), .prev_o(prev_w)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    irq_bank #(.N_LINES(N_LINES)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .sync_i(sync_w), .prev_i(prev_w),
      .we_i(bus_we && addr_ok && (bank_w == b[0])),
      .sel_i(sel_w), .wdata_i(bus_wdata[N_LINES-1:0]),
      .rword_o(rword[b]), .irq_o(irq_v[b])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_re && addr_ok) rd_next[N_LINES-1:0] = rword[bank_w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  assign irq_norm_o = irq_v[0];
  assign irq_fast_o = irq_v[1];

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel_w == SEL_ACK) |=> (bus_rdata == '0)); // R8
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0)); // R13
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !addr_ok) |=> (bus_rdata == '0)); // R2
endmodule

// File: tb/tb_irq_ctrl_dual.sv
`timescale 1ns/1ps
module tb_irq_ctrl_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_lines = '0;
  logic        irq_norm_o, irq_fast_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_dual dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  localparam logic [7:0] O_RAW = 8'h00, O_EN = 8'h04, O_ACK = 8'h08,
                         O_TRIG = 8'h0C, O_SENS = 8'h10, O_STAT = 8'h14,
                         FAST = 8'h20;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_re = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int b, input int s);
    return {16'h5A00 + 16'(b * 16 + s), 16'hC3E1 ^ 16'(s * 4099)};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e, pol, msk, base, nv, rise, fall;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset values on every mapped register of both banks
    chk("R1 irq_norm", {31'b0, irq_norm_o}, 32'h0);
    chk("R1 irq_fast", {31'b0, irq_fast_o}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 6; s++) begin
        rd(8'(b * 32 + s * 4), v);
        chk("R1/R2 reset reg", v, 32'h0);
      end

    // R3 / R11: read-back of enable, trigger, sense in both banks, written all first
    for (int b = 0; b < 2; b++)
      for (int s = 1; s < 5; s++)
        if (s != 2) wr(8'(b * 32 + s * 4), pat(b, s));
    for (int b = 0; b < 2; b++)
      for (int s = 1; s < 5; s++)
        if (s != 2) begin
          rd(8'(b * 32 + s * 4), v);
          chk("R3/R11 readback", v, pat(b, s));
        end

    // R2: unmapped addresses read zero and writes to them change nothing
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h18, v); chk("R2 unmapped 0x18", v, 32'h0);
    rd(8'h3C, v); chk("R2 unmapped 0x3C", v, 32'h0);
    rd(O_EN, v);  chk("R2 enable untouched", v, pat(0, 1));
    // R13: read data returns to zero one cycle after the read
    @(posedge clk); @(negedge clk);
    chk("R13 idle rdata", bus_rdata, 32'h0);

    // R4 / R5 / R9 / R10 / R11: level sweep on the normal bank, fast bank disabled
    pol = 32'h0000_FFFF; msk = 32'hFF00_FF00;
    wr(O_TRIG, 32'h0); wr(O_SENS, pol); wr(O_EN, msk);
    wr(FAST + O_EN, 32'h0);
    foreach (v[i]) ;
    for (int p = 0; p < 6; p++) begin
      case (p)
        0: base = 32'h0000_0000;
        1: base = 32'hFFFF_FFFF;
        2: base = 32'hA5A5_5A5A;
        3: base = 32'h8000_0001;
        4: base = 32'h0F0F_F0F0;
        default: base = 32'h0000_FF00;
      endcase
      irq_lines = base;
      tick(3);
      e = base ^ pol;
      rd(O_RAW, v);  chk("R4/R5 level raw", v, e);
      rd(O_STAT, v); chk("R9 status", v, e & msk);
      chk("R10 irq_norm", {31'b0, irq_norm_o}, {31'b0, |(e & msk)});
      chk("R11 irq_fast quiet", {31'b0, irq_fast_o}, 32'h0);
    end
    // R10: zero enable keeps the output low while lines are pending
    wr(O_EN, 32'h0);
    rd(O_RAW, v);
    chk("R10 pending present", {31'b0, v != 0}, 32'h1);
    chk("R10 masked output", {31'b0, irq_norm_o}, 32'h0);

    // R4: level latency, two edges from input to output
    wr(O_SENS, 32'h0); wr(O_EN, 32'h1); irq_lines = 32'h0; tick(3);
    irq_lines = 32'h1;
    tick(1); chk("R4 not yet after 1 edge", {31'b0, irq_norm_o}, 32'h0);
    tick(1); chk("R4 due after 2 edges", {31'b0, irq_norm_o}, 32'h1);
    irq_lines = 32'h0; tick(2);
    chk("R4 follows input low", {31'b0, irq_norm_o}, 32'h0);

    // R6 / R7 / R8: edge sweep, odd lines falling, even lines rising
    pol = 32'hAAAA_AAAA;
    wr(O_TRIG, 32'hFFFF_FFFF); wr(O_SENS, pol); wr(O_EN, 32'hFFFF_FFFF);
    for (int p = 0; p < 3; p++) begin
      case (p)
        0: begin base = 32'h0000_0000; nv = 32'hFFFF_FFFF; end
        1: begin base = 32'hFFFF_FFFF; nv = 32'h0F0F_3C3C; end
        default: begin base = 32'h3333_CCCC; nv = 32'h5555_AAAA; end
      endcase
      irq_lines = base; tick(4);
      wr(O_ACK, 32'hFFFF_FFFF);
      rd(O_RAW, v); chk("R8 cleared before edge", v, 32'h0);
      irq_lines = nv; tick(4);
      rise = ~base & nv; fall = base & ~nv;
      e = (rise & ~pol) | (fall & pol);
      rd(O_RAW, v);  chk("R6/R7 edge latched", v, e);
      rd(O_STAT, v); chk("R9 edge status", v, e);
      wr(O_ACK, 32'h0000_FFFF);
      rd(O_RAW, v);  chk("R8 partial ack", v, e & 32'hFFFF_0000);
      rd(O_ACK, v);  chk("R8 ack reads zero", v, 32'h0);
    end

    // R6 / R12: rising line 0, latency and same-cycle ack versus new edge
    wr(O_SENS, 32'h0); wr(O_EN, 32'h1); irq_lines = 32'h0; tick(4);
    wr(O_ACK, 32'hFFFF_FFFF);
    irq_lines = 32'h1;
    tick(2); chk("R6 not yet after 2 edges", {31'b0, irq_norm_o}, 32'h0);
    tick(1); chk("R6 due after 3 edges", {31'b0, irq_norm_o}, 32'h1);
    irq_lines = 32'h0; tick(4);
    chk("R6 held after input falls", {31'b0, irq_norm_o}, 32'h1);
    irq_lines = 32'h1; tick(2);
    wr(O_ACK, 32'h1);   // commits on the edge that latches the new event
    rd(O_RAW, v); chk("R12 edge wins over ack", v, 32'h1);
    wr(O_ACK, 32'h1);
    rd(O_RAW, v); chk("R8 ack without edge", v, 32'h0);

    // R11: fast bank alone raises its output
    wr(O_EN, 32'h0);
    wr(FAST + O_TRIG, 32'h0); wr(FAST + O_SENS, 32'h0); wr(FAST + O_EN, 32'h4);
    irq_lines = 32'h4; tick(3);
    chk("R11 fast output", {31'b0, irq_fast_o}, 32'h1);
    chk("R11 normal output", {31'b0, irq_norm_o}, 32'h0);
    rd(FAST + O_STAT, v); chk("R11 fast status", v, 32'h4);
    rd(O_STAT, v);        chk("R11 normal status", v, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule